// File: doc/BRIEF.md
# Sorted Sliding-Window Merge Engine

This block holds the last WS tuples of a stream in a register array, always in ascending key order, so that a downstream aggregator can read the whole window at once on a wide parallel bus. The producer hands it one batch of WA keys per window step. The keys in a batch are already sorted. The engine then updates the array in place. First, one compaction pass drops the WA tuples that arrived earliest and closes the gaps. Then each new key is placed in turn: a binary search finds its slot, and the entries above that slot shift up by one.

Each stored entry carries an arrival tag, taken from a small wrapping counter. The tag is the only thing eviction looks at, so the key values never affect which tuples leave. While the window is still filling, no entry is old enough to leave, and the occupancy simply grows. The producer watches `busy`. The aggregator waits for the one-cycle `win_done` strobe, then reads `win_keys`, `win_tags` and `win_count`.

Top module: `swin_engine`

## Requirements
- R1: After reset, `busy` is 0, `win_done` is 0 and `win_count` is 0.
- R2: A batch is taken only at a rising clock edge where `batch_valid` is 1 and `busy` is 0. While `busy` is 1, `batch_valid` and `batch_keys` are ignored. Such stimulus changes neither the window contents nor the count, and it produces no extra `win_done`.
- R3: While fewer than WS tuples have arrived, nothing is evicted, and `win_count` grows by exactly WA per step. `win_count` never exceeds WS.
- R4: Once the window is full, every step removes exactly the WA tuples that arrived earliest, whatever their key values.
- R5: At each `win_done`, slots 0 to `win_count`-1 of `win_keys` hold exactly the keys of the most recent min(arrivals, WS) tuples. Slot i sits at bits [i*KW +: KW]. The keys are non-decreasing from slot 0 upwards.
- R6: Equal keys sit in arrival order, with the earlier arrival in the lower slot. This holds both against keys already stored and within one batch. Batch lane j sits at bits [j*KW +: KW], lane 0 arrived first, and the lanes are non-decreasing.
- R7: `busy` is 1 from the cycle after a batch is accepted until `win_done` has been issued. `win_done` is high for exactly one cycle, once per accepted batch. `busy` falls in the following cycle.
- R8: After reset, tuples are numbered in arrival order starting at 0. The number wraps modulo 2^SW, where SW = clog2(WS)+1. Each slot of `win_tags` (bits [i*SW +: SW]) reports the number of the tuple in the matching `win_keys` slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| batch_valid | input | 1 | A sorted batch is offered |
| batch_keys | input | WA*KW | WA keys, lane 0 first, non-decreasing |
| busy | output | 1 | A step is in progress; new batches are not taken |
| win_done | output | 1 | One-cycle strobe: window updated and stable |
| win_count | output | clog2(WS+1) | Number of valid slots |
| win_keys | output | WS*KW | Window keys, slot 0 smallest |
| win_tags | output | WS*SW | Arrival tag of each slot |

## Verification
A reference queue of arrivals is kept, and each expected window is built from it by a stable sort. Every strobe is compared slot by slot, on keys and on tags.

The stimulus covers several distinct situations:
- The fill phase shows that occupancy grows without any eviction.
- Old batches of large keys followed by small keys show that eviction follows age and not value.
- Strictly rising and strictly falling streams drive the insert point to the top and to the bottom of the array.
- Runs of identical keys expose any unstable placement through the tag order.
- A long pseudo-random stream makes the tag counter wrap.
- Batches offered while the engine is working must leave no trace.

// File: rtl/swin_pkg.sv
package swin_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_SEARCH,
    ST_SHIFT,
    ST_DONE
  } swin_state_e;

endpackage

// File: rtl/swin_compact.sv
// Age-based eviction: drops entries whose arrival distance from the next
// tag exceeds WS-WA and packs the survivors downward, keeping their order.
module swin_compact #(
  parameter int WS = 16,
  parameter int WA = 4,
  parameter int KW = 16,
  parameter int SW = 5,
  parameter int CW = 5
) (
  input  logic [WS*KW-1:0] keys_i,
  input  logic [WS*SW-1:0] tags_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [SW-1:0]    next_tag_i,
  output logic [WS*KW-1:0] keys_o,
  output logic [WS*SW-1:0] tags_o,
  output logic [CW-1:0]    cnt_o
);

  localparam logic [SW-1:0] MAX_AGE = SW'(WS - WA);

  logic          keep [WS];
  logic [CW-1:0] rank [WS];

  always_comb begin
    logic [CW-1:0] run;
    run = '0;
    for (int i = 0; i < WS; i++) begin
      logic [SW-1:0] age;
      age     = next_tag_i - tags_i[i*SW +: SW];
      keep[i] = (CW'(i) < cnt_i) && (age <= MAX_AGE);
      rank[i] = run;
      if (keep[i]) run = run + CW'(1);
    end
    cnt_o = run;
  end

  always_comb begin
    keys_o = keys_i;
    tags_o = tags_i;
    for (int j = 0; j < WS; j++) begin
      for (int i = j; i < WS; i++) begin
        if (keep[i] && rank[i] == CW'(j)) begin
          keys_o[j*KW +: KW] = keys_i[i*KW +: KW];
          tags_o[j*SW +: SW] = tags_i[i*SW +: SW];
        end
      end
    end
  end

endmodule

// File: rtl/swin_bsearch.sv
// One step of an upper-bound binary search over slots [lo, hi).
// Ties move right, so a new key lands after every equal stored key.
module swin_bsearch #(
  parameter int WS = 16,
  parameter int KW = 16,
  parameter int CW = 5
) (
  input  logic [WS*KW-1:0] keys_i,
  input  logic [CW-1:0]    lo_i,
  input  logic [CW-1:0]    hi_i,
  input  logic [KW-1:0]    key_i,
  output logic [CW-1:0]    lo_o,
  output logic [CW-1:0]    hi_o,
  output logic             done_o
);

  logic [CW:0]   sum;
  logic [CW-1:0] mid;
  logic [KW-1:0] mid_key;

  assign sum    = {1'b0, lo_i} + {1'b0, hi_i};
  assign mid    = CW'(sum >> 1);
  assign done_o = (lo_i == hi_i);

  always_comb begin
    mid_key = '0;
    for (int j = 0; j < WS; j++) begin
      if (mid == CW'(j)) mid_key = keys_i[j*KW +: KW];
    end
  end

  always_comb begin
    lo_o = lo_i;
    hi_o = hi_i;
    if (!done_o) begin
      if (mid_key <= key_i) lo_o = mid + CW'(1);
      else                  hi_o = mid;
    end
  end

endmodule

// File: rtl/swin_insert.sv
// Opens slot pos_i by moving every entry above it up one place,
// then writes the new key and tag into the opened slot.
module swin_insert #(
  parameter int WS = 16,
  parameter int KW = 16,
  parameter int SW = 5,
  parameter int CW = 5
) (
  input  logic [WS*KW-1:0] keys_i,
  input  logic [WS*SW-1:0] tags_i,
  input  logic [CW-1:0]    pos_i,
  input  logic [KW-1:0]    key_i,
  input  logic [SW-1:0]    tag_i,
  output logic [WS*KW-1:0] keys_o,
  output logic [WS*SW-1:0] tags_o
);

  for (genvar g = 0; g < WS; g++) begin : g_slot
    if (g == 0) begin : g_bottom
      always_comb begin
        if (pos_i == CW'(0)) begin
          keys_o[0 +: KW] = key_i;
          tags_o[0 +: SW] = tag_i;
        end else begin
          keys_o[0 +: KW] = keys_i[0 +: KW];
          tags_o[0 +: SW] = tags_i[0 +: SW];
        end
      end
    end else begin : g_upper
      always_comb begin
        if (CW'(g) > pos_i) begin
          keys_o[g*KW +: KW] = keys_i[(g-1)*KW +: KW];
          tags_o[g*SW +: SW] = tags_i[(g-1)*SW +: SW];
        end else if (CW'(g) == pos_i) begin
          keys_o[g*KW +: KW] = key_i;
          tags_o[g*SW +: SW] = tag_i;
        end else begin
          keys_o[g*KW +: KW] = keys_i[g*KW +: KW];
          tags_o[g*SW +: SW] = tags_i[g*SW +: SW];
        end
      end
    end
  end

endmodule

// File: rtl/swin_engine.sv
module swin_engine
  import swin_pkg::*;
#(
  parameter  int WS = 16,
  parameter  int WA = 4,
  parameter  int KW = 16,
  localparam int SW = $clog2(WS) + 1,
  localparam int CW = $clog2(WS + 1),
  localparam int IW = (WA > 1) ? $clog2(WA) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             batch_valid,
  input  logic [WA*KW-1:0] batch_keys,
  output logic             busy,
  output logic             win_done,
  output logic [CW-1:0]    win_count,
  output logic [WS*KW-1:0] win_keys,
  output logic [WS*SW-1:0] win_tags
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // state
  swin_state_e      state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SW-1:0]    next_tag_q, next_tag_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [CW-1:0]    lo_q, lo_d, hi_q, hi_d;
  logic [WS*KW-1:0] keys_q, keys_d;
  logic [WS*SW-1:0] tags_q, tags_d;
  logic [WA*KW-1:0] batch_q;

  // datapath helpers
  logic [WS*KW-1:0] cmp_keys, ins_keys;
  logic [WS*SW-1:0] cmp_tags, ins_tags;
  logic [CW-1:0]    cmp_cnt;
  logic [CW-1:0]    bs_lo, bs_hi;
  logic             bs_done;
  logic [KW-1:0]    cur_key;
  logic [SW-1:0]    cur_tag;
  logic             arr_en, batch_en;

  always_comb begin
    cur_key = '0;
    for (int j = 0; j < WA; j++) begin
      if (idx_q == IW'(j)) cur_key = batch_q[j*KW +: KW];
    end
  end
  assign cur_tag = next_tag_q + SW'(idx_q);

  swin_compact #(.WS(WS), .WA(WA), .KW(KW), .SW(SW), .CW(CW)) u_compact (
    .keys_i     (keys_q),
    .tags_i     (tags_q),
    .cnt_i      (cnt_q),
    .next_tag_i (next_tag_q),
    .keys_o     (cmp_keys),
    .tags_o     (cmp_tags),
    .cnt_o      (cmp_cnt)
  );

  swin_bsearch #(.WS(WS), .KW(KW), .CW(CW)) u_search (
    .keys_i (keys_q),
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .key_i  (cur_key),
    .lo_o   (bs_lo),
    .hi_o   (bs_hi),
    .done_o (bs_done)
  );

  swin_insert #(.WS(WS), .KW(KW), .SW(SW), .CW(CW)) u_insert (
    .keys_i (keys_q),
    .tags_i (tags_q),
    .pos_i  (lo_q),
    .key_i  (cur_key),
    .tag_i  (cur_tag),
    .keys_o (ins_keys),
    .tags_o (ins_tags)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    next_tag_d = next_tag_q;
    idx_d      = idx_q;
    lo_d       = lo_q;
    hi_d       = hi_q;
    keys_d     = keys_q;
    tags_d     = tags_q;
    arr_en     = 1'b0;
    batch_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (batch_valid) begin
          batch_en = 1'b1;
          state_d  = ST_EVICT;
        end
      end
      ST_EVICT: begin
        arr_en  = 1'b1;
        keys_d  = cmp_keys;
        tags_d  = cmp_tags;
        cnt_d   = cmp_cnt;
        idx_d   = '0;
        lo_d    = '0;
        hi_d    = cmp_cnt;
        state_d = ST_SEARCH;
      end
      ST_SEARCH: begin
        if (bs_done) begin
          state_d = ST_SHIFT;
        end else begin
          lo_d = bs_lo;
          hi_d = bs_hi;
        end
      end
      ST_SHIFT: begin
        arr_en = 1'b1;
        keys_d = ins_keys;
        tags_d = ins_tags;
        cnt_d  = cnt_q + CW'(1);
        if (idx_q == IW'(WA - 1)) begin
          next_tag_d = next_tag_q + SW'(WA);
          state_d    = ST_DONE;
        end else begin
          // the batch is sorted: the next key cannot land below this slot
          idx_d   = idx_q + IW'(1);
          lo_d    = lo_q + CW'(1);
          hi_d    = cnt_q + CW'(1);
          state_d = ST_SEARCH;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      next_tag_q <= '0;
      idx_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      next_tag_q <= next_tag_d;
      idx_q      <= idx_d;
      lo_q       <= lo_d;
      hi_q       <= hi_d;
    end
  end

  // datapath registers, no reset, written under enable
  always_ff @(posedge clk) begin
    if (arr_en) begin
      keys_q <= keys_d;
      tags_q <= tags_d;
    end
    if (batch_en) batch_q <= batch_keys;
  end

  assign busy      = (state_q != ST_IDLE);
  assign win_done  = (state_q == ST_DONE);
  assign win_count = cnt_q;
  assign win_keys  = keys_q;
  assign win_tags  = tags_q;

  // checks
  AST_TAKE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && batch_valid) |=> busy); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_count <= CW'(WS)); // R3
  AST_FILL_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_EVICT && cnt_q <= CW'(WS - WA)) |=> (cnt_q == $past(cnt_q))); // R3
  AST_EVICT_ROOM: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_EVICT) |=> (cnt_q <= CW'(WS - WA))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_done |=> !win_done); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !win_done) |=> busy); // R7
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_done |=> !busy); // R7

  for (genvar g = 1; g < WS; g++) begin : g_order_chk
    AST_WINDOW_ORDERED: assert property (@(posedge clk) disable iff (!rst_n_s)
      (state_q == ST_IDLE && CW'(g) < cnt_q) |->
        (keys_q[(g-1)*KW +: KW] <= keys_q[g*KW +: KW])); // R5
  end

endmodule

// File: tb/sim_swin_engine.sv
module sim_swin_engine;

  localparam int WS = 16;
  localparam int WA = 4;
  localparam int KW = 16;
  localparam int SW = $clog2(WS) + 1;
  localparam int CW = $clog2(WS + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             batch_valid;
  logic [WA*KW-1:0] batch_keys;
  logic             busy;
  logic             win_done;
  logic [CW-1:0]    win_count;
  logic [WS*KW-1:0] win_keys;
  logic [WS*SW-1:0] win_tags;

  always #10 clk = ~clk;

  swin_engine #(.WS(WS), .WA(WA), .KW(KW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .batch_valid (batch_valid),
    .batch_keys  (batch_keys),
    .busy        (busy),
    .win_done    (win_done),
    .win_count   (win_count),
    .win_keys    (win_keys),
    .win_tags    (win_tags)
  );

  typedef struct {
    int unsigned k [WS];
    int unsigned t [WS];
    int          cnt;
    string       req;
  } exp_t;

  exp_t        expq [$];
  int unsigned arrivals [$];
  int          checks = 0;
  int          fails  = 0;
  string       phase  = "R5";
  int unsigned lfsr   = 32'h1ACE_B00C;
  bit          running = 1'b0;
  bit          prev_done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // expected window: the last min(n, WS) arrivals, stably sorted by key
  function automatic exp_t snapshot(input string req);
    exp_t e;
    int   n, w, base;
    n    = arrivals.size();
    w    = (n < WS) ? n : WS;
    base = n - w;
    for (int i = 0; i < WS; i++) begin
      e.k[i] = 0;
      e.t[i] = 0;
    end
    for (int i = 0; i < w; i++) begin
      int unsigned kk, tt;
      int          p;
      kk = arrivals[base + i];
      tt = (base + i) % (1 << SW);
      p  = i;
      while (p > 0 && e.k[p-1] > kk) begin
        e.k[p] = e.k[p-1];
        e.t[p] = e.t[p-1];
        p--;
      end
      e.k[p] = kk;
      e.t[p] = tt;
    end
    e.cnt = w;
    e.req = req;
    return e;
  endfunction

  // driver: waits for an idle engine, offers one batch, records expectation
  task automatic send_batch(input int unsigned kv [WA]);
    int unsigned s [WA];
    s = kv;
    for (int i = 1; i < WA; i++) begin
      for (int j = i; j > 0 && s[j-1] > s[j]; j--) begin
        int unsigned tmp;
        tmp    = s[j];
        s[j]   = s[j-1];
        s[j-1] = tmp;
      end
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    for (int j = 0; j < WA; j++) batch_keys[j*KW +: KW] = KW'(s[j]);
    batch_valid = 1'b1;
    for (int j = 0; j < WA; j++) arrivals.push_back(s[j] % (1 << KW));
    expq.push_back(snapshot(phase));
    @(negedge clk);
    batch_valid = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", longint'(busy), 1);
  endtask

  task automatic send_random(input int unsigned mask);
    int unsigned kv [WA];
    for (int j = 0; j < WA; j++) kv[j] = rnd() & mask;
    send_batch(kv);
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || expq.size() != 0) @(negedge clk);
  endtask

  // monitor: compares each done strobe against the oldest expectation
  always @(negedge clk) begin
    if (running) begin
      if (win_done) begin
        check(!prev_done, "R7", "done width", 2, 1);
        if (expq.size() == 0) begin
          check(1'b0, "R2", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(int'(win_count) == e.cnt, (e.req == "R3") ? "R3" : "R5",
                "count", longint'(win_count), e.cnt);
          for (int i = 0; i < e.cnt; i++) begin
            check(int'(win_keys[i*KW +: KW]) == e.k[i], e.req, "key slot",
                  longint'(win_keys[i*KW +: KW]), e.k[i]);
            check(int'(win_tags[i*SW +: SW]) == e.t[i], "R8", "tag slot",
                  longint'(win_tags[i*SW +: SW]), e.t[i]);
          end
        end
      end
      prev_done = win_done;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n       = 1'b1;
    batch_valid = 1'b0;
    batch_keys  = '0;
    #3 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1", "busy", longint'(busy), 0);
    check(win_done == 1'b0, "R1", "done", longint'(win_done), 0);
    check(win_count == '0, "R1", "count", longint'(win_count), 0);
    running = 1'b1;

    // R3 fill phase, no eviction before WS arrivals
    phase = "R3";
    send_batch('{10, 20, 30, 40});
    send_batch('{5, 15, 25, 35});
    send_batch('{1, 2, 3, 50});
    send_batch('{12, 12, 45, 60});
    drain();
    check(int'(win_count) == WS, "R3", "full count", longint'(win_count), WS);

    // R4 eviction by age: old large keys leave before new small ones
    phase = "R4";
    for (int b = 0; b < 4; b++) send_batch('{900 + b, 910 + b, 920 + b, 930 + b});
    for (int b = 0; b < 4; b++) send_batch('{b, 4 + b, 8 + b, 12 + b});
    drain();
    for (int i = 0; i < WS; i++)
      check(int'(win_keys[i*KW +: KW]) < 900, "R4", "stale key left",
            longint'(win_keys[i*KW +: KW]), 0);

    // R5 rising stream (inserts at top) and falling stream (inserts at bottom)
    phase = "R5";
    for (int b = 0; b < 5; b++) send_batch('{100 + 4*b, 101 + 4*b, 102 + 4*b, 103 + 4*b});
    for (int b = 0; b < 5; b++) send_batch('{60 - 4*b, 61 - 4*b, 62 - 4*b, 63 - 4*b});

    // R6 runs of equal keys, checked through the tag order
    phase = "R6";
    for (int b = 0; b < 6; b++) send_batch('{7, 7, 7, 7});
    send_batch('{6, 7, 7, 8});
    send_batch('{7, 7, 8, 8});
    drain();

    // R2 batches offered while busy are ignored
    phase = "R2";
    send_batch('{300, 301, 302, 303});
    batch_valid = 1'b1;
    batch_keys  = {WA{KW'(16'h0001)}};
    forever begin
      @(negedge clk);
      if (!busy) begin
        batch_valid = 1'b0;
        break;
      end
      batch_keys = {WA{KW'(rnd())}};
    end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2", "pending after ignore", expq.size(), 0);
    check(int'(win_count) == WS, "R2", "count after ignore", longint'(win_count), WS);
    send_batch('{305, 306, 307, 308});
    drain();

    // R8 long pseudo-random stream wraps the arrival tags
    phase = "R8";
    for (int b = 0; b < 30; b++) send_random(32'h0000_003F);
    for (int b = 0; b < 10; b++) send_random(32'h0000_FFFF);
    drain();

    running = 1'b0;
    finish_run();
  end

endmodule